// File: doc/BRIEF.md
# Prioritising Interrupt Controller

This block collects a parameterised number of level-sensitive, active-high interrupt lines and presents the single most urgent one to one CPU. Each line has its own enable, pending, active and 8-bit priority state. A combinational selector picks the best candidate among lines that are enabled, pending and not already in service. The candidate is then compared against a CPU priority mask and gated by two enables, one for forwarding and one for the CPU side. When a candidate passes, the single IRQ output is raised.

Software reaches the block through a 32-bit register bus with a single-cycle strobe. Read data appears in the cycle after the read.

To service an interrupt, software reads the acknowledge register, which claims the winning interrupt and marks it in service. It then writes the same ID to the end-of-interrupt register when it has finished. An acknowledge that finds nothing eligible returns the reserved spurious ID 1023. A separate reset register clears every in-service mark at once, which recovers an interface left in a confused state.

Top module: `irqc_top`

## Requirements
- R1: After reset every enable, software-pending, active and priority bit is zero, the two enables and the mask are zero, `irq_out` is low, and an acknowledge read returns 0x3FF.
- R2: The set-enable bank (word w at 0x100+4w) and the clear-enable bank (0x140+4w) control interrupt n through word n/32, bit n%32. A 1 written to a bit sets or clears that bit, and a 0 leaves it unchanged. A read of either bank returns the current enable word.
- R3: An interrupt is pending while its input is high or its software-pending bit is set. Software-pending bits are set at 0x180+4w and cleared at 0x1C0+4w. A read of either address returns the combined pending word.
- R4: Priority of interrupt k occupies bits 8*(k%4)+7 down to 8*(k%4) of the register at 0x400+4*(k/4). These registers read back as written.
- R5: Among enabled, pending, non-active interrupts, the one with the numerically lowest priority wins. When priorities are equal, the lowest ID wins.
- R6: The winner is signalled only if its priority is strictly below the mask held in bits 7:0 at 0x008. A mask of 0xFF passes every priority except 0xFF.
- R7: Nothing is signalled or acknowledged unless bit 0 of the forwarding control register (0x000) and bit 0 of the CPU control register (0x004) are both 1.
- R8: A read of the acknowledge register (0x00C) returns the winner's ID in bits 9:0, sets its active bit and clears its software-pending bit. When nothing qualifies, the read returns 0x3FF and changes no state.
- R9: An active interrupt is not signalled or acknowledged again. This holds even while its input stays high. Writing its ID to the end-of-interrupt register (0x010) clears its active bit. An end-of-interrupt for an ID that is not active, or that is out of range, has no effect. Active bits can also be set at 0x200+4w and cleared at 0x240+4w, and both addresses read back the active word.
- R10: Writing 0 to the active-reset register (0x014) clears every active bit. Writing a nonzero value there has no effect.
- R11: `irq_out` is registered. It reflects the state and inputs present at the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_IRQ | Level-sensitive, active-high interrupt lines |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
A register write takes effect at the rising edge that samples it. Read data is due one edge after the read strobe. `irq_out` lags any change in state or input by one further edge. The bench drives on falling edges and flags each access or IRQ probe with a marker that is registered in the bench itself. Its monitor compares on the falling edge after that marker is captured, which places every comparison exactly on the edge where the result is due. The order in which expected items are queued follows the acknowledge sequence that the priority, tie and mask rules predict.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared constants for the interrupt controller: register offsets,
// bank region codes and the reserved spurious identifier.
package irqc_pkg;
    localparam int          ID_W      = 10;
    localparam int          PRIO_W    = 8;
    localparam logic [9:0]  SPURIOUS  = 10'h3FF;

    localparam logic [11:0] A_DCTL    = 12'h000;
    localparam logic [11:0] A_CCTL    = 12'h004;
    localparam logic [11:0] A_MASK    = 12'h008;
    localparam logic [11:0] A_ACK     = 12'h00C;
    localparam logic [11:0] A_EOI     = 12'h010;
    localparam logic [11:0] A_ARST    = 12'h014;

    // Region codes taken from address bits 11:6, 16 words per region
    localparam logic [5:0]  R_SET_EN  = 6'h04;
    localparam logic [5:0]  R_CLR_EN  = 6'h05;
    localparam logic [5:0]  R_SET_PD  = 6'h06;
    localparam logic [5:0]  R_CLR_PD  = 6'h07;
    localparam logic [5:0]  R_SET_AC  = 6'h08;
    localparam logic [5:0]  R_CLR_AC  = 6'h09;
    // Priority region: address bits 11:10 == 2'b01
    localparam logic [1:0]  R_PRIO    = 2'b01;
endpackage

// File: rtl/irqc_bitbank.sv
// Module irqc_bitbank
// Holds one state bit per interrupt. Software can set or clear the bits a
// 32-bit word at a time, and hardware can set or clear individual bits.
// When a set and a clear hit the same bit in the same cycle, the clear wins.
// Assumes N_IRQ is a multiple of 32 and no larger than 512.
module irqc_bitbank #(
    parameter int N_IRQ = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_set,
    input  logic             sw_clr,
    input  logic [3:0]       word_idx,
    input  logic [31:0]      wdata,
    input  logic [N_IRQ-1:0] hw_set,
    input  logic [N_IRQ-1:0] hw_clr,
    output logic [N_IRQ-1:0] bits_q
);
    localparam int NW = N_IRQ / 32;

    logic [N_IRQ-1:0] set_m;
    logic [N_IRQ-1:0] clr_m;

    // Expand a software word write into a per-interrupt mask
    generate
        for (genvar w = 0; w < NW; w++) begin : g_word
            assign set_m[w*32 +: 32] = (sw_set && (word_idx == 4'(w))) ? wdata : '0;
            assign clr_m[w*32 +: 32] = (sw_clr && (word_idx == 4'(w))) ? wdata : '0;
        end
    endgenerate

    // State update: set first, then clear, so a clear wins a collision
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= (bits_q | set_m | hw_set) & ~(clr_m | hw_clr);
    end
endmodule

// File: rtl/irqc_prio_file.sv
// Module irqc_prio_file
// Stores an 8-bit priority for each interrupt, four to a 32-bit word.
// Each word is written whole. Assumes N_IRQ is a multiple of 4.
module irqc_prio_file #(
    parameter int N_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [7:0]         word_idx,
    input  logic [31:0]        wdata,
    output logic [N_IRQ*8-1:0] prio_flat
);
    localparam int NPW = N_IRQ / 4;

    generate
        for (genvar k = 0; k < NPW; k++) begin : g_pw
            logic [31:0] word_q;
            // Word k captures the write data when it is addressed
            always_ff @(posedge clk) begin
                if (!rst_n)                           word_q <= '0;
                else if (we && (word_idx == 8'(k)))   word_q <= wdata;
            end
            assign prio_flat[k*32 +: 32] = word_q;
        end
    endgenerate
endmodule

// File: rtl/irqc_select.sv
// Module irqc_select
// Combinational selector. Among the candidate lines it finds the one with
// the lowest priority value, and on equal values the lowest index.
// The clock and reset are used only by the embedded check.
module irqc_select #(
    parameter int N_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IRQ-1:0]   cand,
    input  logic [N_IRQ*8-1:0] prio_flat,
    output logic               found,
    output logic [9:0]         win_id,
    output logic [7:0]         win_prio
);
    // Linear scan; a strict compare keeps the earlier (lower) ID on ties
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = 8'hFF;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand[i] && (!found || (prio_flat[i*8 +: 8] < win_prio))) begin
                found    = 1'b1;
                win_id   = 10'(i);
                win_prio = prio_flat[i*8 +: 8];
            end
        end
    end

    // R5
    pick_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand) |-> found);
endmodule

// File: rtl/irqc_top.sv
// Module irqc_top
// Single-CPU prioritising interrupt controller. It decodes the register bus,
// holds the enable, pending, active and priority state, gates the winner
// with the mask and the two enables, and carries out the acknowledge and
// end-of-interrupt handshake. Assumes N_IRQ is a multiple of 32 and no
// larger than 512. Read data is registered one cycle after the strobe.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_out
);
    localparam int NW  = N_IRQ / 32;
    localparam int NPW = N_IRQ / 4;

    logic             wr, rd;
    logic [5:0]       region;
    logic [3:0]       widx;
    logic [7:0]       pidx;
    logic             dist_en, cpu_en;
    logic [7:0]       mask_q;
    logic [N_IRQ-1:0] en_q, spend_q, act_q, pend, cand;
    logic [N_IRQ-1:0] ack_vec, eoi_vec, act_clr;
    logic [N_IRQ*8-1:0] prio_flat;
    logic             found, qualify, ack_rd, ack_take, eoi_wr, arst;
    logic [9:0]       sel_id;
    logic [7:0]       sel_prio;
    logic [31:0]      en_w, pd_w, ac_w, pr_w, rd_val;

    // Bus decode
    assign wr     = bus_en & bus_we;
    assign rd     = bus_en & ~bus_we;
    assign region = bus_addr[11:6];
    assign widx   = bus_addr[5:2];
    assign pidx   = bus_addr[9:2];
    assign ack_rd = rd && (bus_addr == A_ACK);
    assign eoi_wr = wr && (bus_addr == A_EOI);
    assign arst   = wr && (bus_addr == A_ARST) && (bus_wdata == 32'd0);

    irqc_bitbank #(.N_IRQ(N_IRQ)) u_enable (
        .clk(clk), .rst_n(rst_n),
        .sw_set(wr && region == R_SET_EN), .sw_clr(wr && region == R_CLR_EN),
        .word_idx(widx), .wdata(bus_wdata),
        .hw_set('0), .hw_clr('0), .bits_q(en_q));

    irqc_bitbank #(.N_IRQ(N_IRQ)) u_softpend (
        .clk(clk), .rst_n(rst_n),
        .sw_set(wr && region == R_SET_PD), .sw_clr(wr && region == R_CLR_PD),
        .word_idx(widx), .wdata(bus_wdata),
        .hw_set('0), .hw_clr(ack_vec), .bits_q(spend_q));

    irqc_bitbank #(.N_IRQ(N_IRQ)) u_active (
        .clk(clk), .rst_n(rst_n),
        .sw_set(wr && region == R_SET_AC), .sw_clr(wr && region == R_CLR_AC),
        .word_idx(widx), .wdata(bus_wdata),
        .hw_set(ack_vec), .hw_clr(act_clr), .bits_q(act_q));

    irqc_prio_file #(.N_IRQ(N_IRQ)) u_prio (
        .clk(clk), .rst_n(rst_n),
        .we(wr && bus_addr[11:10] == R_PRIO), .word_idx(pidx),
        .wdata(bus_wdata), .prio_flat(prio_flat));

    // Candidate set: enabled, pending by level or software, not in service
    assign pend = spend_q | irq_in;
    assign cand = en_q & pend & ~act_q;

    irqc_select #(.N_IRQ(N_IRQ)) u_select (
        .clk(clk), .rst_n(rst_n), .cand(cand), .prio_flat(prio_flat),
        .found(found), .win_id(sel_id), .win_prio(sel_prio));

    // Gate the winner with both enables and the mask
    assign qualify  = found && dist_en && cpu_en && (sel_prio < mask_q);
    assign ack_take = ack_rd && qualify;

    // One-hot claim and release vectors
    generate
        for (genvar i = 0; i < N_IRQ; i++) begin : g_hs
            assign ack_vec[i] = ack_take && (sel_id == 10'(i));
            assign eoi_vec[i] = eoi_wr && (bus_wdata[9:0] == 10'(i));
        end
    endgenerate
    assign act_clr = eoi_vec | {N_IRQ{arst}};

    // Control registers: forwarding enable, CPU enable, priority mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dist_en <= 1'b0;
            cpu_en  <= 1'b0;
            mask_q  <= 8'h00;
        end else if (wr) begin
            if (bus_addr == A_DCTL) dist_en <= bus_wdata[0];
            if (bus_addr == A_CCTL) cpu_en  <= bus_wdata[0];
            if (bus_addr == A_MASK) mask_q  <= bus_wdata[7:0];
        end
    end

    // Registered interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= qualify;
    end

    // Word selection for bank and priority reads
    always_comb begin
        en_w = '0;
        pd_w = '0;
        ac_w = '0;
        pr_w = '0;
        for (int w = 0; w < NW; w++) begin
            if (widx == 4'(w)) begin
                en_w = en_q[w*32 +: 32];
                pd_w = pend[w*32 +: 32];
                ac_w = act_q[w*32 +: 32];
            end
        end
        for (int k = 0; k < NPW; k++) begin
            if (pidx == 8'(k)) pr_w = prio_flat[k*32 +: 32];
        end
    end

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        if (bus_addr == A_DCTL)                          rd_val = {31'd0, dist_en};
        else if (bus_addr == A_CCTL)                     rd_val = {31'd0, cpu_en};
        else if (bus_addr == A_MASK)                     rd_val = {24'd0, mask_q};
        else if (bus_addr == A_ACK)                      rd_val = {22'd0, qualify ? sel_id : SPURIOUS};
        else if (region == R_SET_EN || region == R_CLR_EN) rd_val = en_w;
        else if (region == R_SET_PD || region == R_CLR_PD) rd_val = pd_w;
        else if (region == R_SET_AC || region == R_CLR_AC) rd_val = ac_w;
        else if (bus_addr[11:10] == R_PRIO)              rd_val = pr_w;
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_val;
    end

    // R8
    ack_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> ((act_q & $past(ack_vec)) == $past(ack_vec)));
    // R8
    ack_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !qualify) |=> (bus_rdata == 32'h0000_03FF));
    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(dist_en && cpu_en));
    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(sel_prio < mask_q));
    // R10
    act_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arst |=> (act_q == '0));
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    irqc_top #(.N_IRQ(N)) i_irqc_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

    always #4 clk = ~clk;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    vectors = 0;
    int    miscompares = 0;
    logic  fire_rd = 1'b0, fire_irq = 1'b0;
    logic  fq_rd = 1'b0, fq_irq = 1'b0;

    // Marker pipeline: a result is due one edge after its request
    always @(posedge clk) begin
        fq_rd  <= fire_rd;
        fq_irq <= fire_irq;
    end

    // Monitor: pop the expected item and compare on the falling edge
    always @(negedge clk) begin
        if (fq_rd || fq_irq) begin
            item_t it;
            logic [31:0] act;
            if (sb.size() == 0) begin
                miscompares++;
                $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
            end else begin
                it = sb.pop_front();
                act = it.is_irq ? {31'd0, irq_out} : bus_rdata;
                vectors++;
                if (act !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; fire_rd = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; fire_rd = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb.push_back(it);
        fire_irq = 1'b1;
        @(negedge clk);
        fire_irq = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        irq_chk(1'b0, "R1 irq low");
        rd_chk(12'h00C, 32'h3FF, "R1 ack spurious");
        rd_chk(12'h100, 32'h0, "R1 enable clear");
        rd_chk(12'h404, 32'h0, "R1 prio clear");
        rd_chk(12'h008, 32'h0, "R1 mask clear");

        // R4 priorities: id5=0x40, id40=0x40, id33=0x80
        wr(12'h404, 32'h0000_4000);
        wr(12'h428, 32'h0000_0040);
        wr(12'h420, 32'h0000_8000);
        rd_chk(12'h404, 32'h0000_4000, "R4 prio readback");
        rd_chk(12'h428, 32'h0000_0040, "R4 prio readback byte0");

        // R2 enables
        wr(12'h100, 32'h0000_0020);
        wr(12'h104, 32'h0000_0102);
        rd_chk(12'h104, 32'h0000_0102, "R2 set-enable");
        wr(12'h104, 32'h0);
        rd_chk(12'h104, 32'h0000_0102, "R2 zero ignored");
        wr(12'h000, 32'h1);
        wr(12'h004, 32'h1);
        wr(12'h008, 32'hFF);
        irq_chk(1'b0, "R11 idle low");

        // R3/R8/R9 single line
        irq_in[33] = 1'b1;
        irq_chk(1'b1, "R3 level pending");
        rd_chk(12'h184, 32'h0000_0002, "R3 pending read");
        rd_chk(12'h00C, 32'd33, "R8 ack id");
        irq_chk(1'b0, "R9 active blocks");
        rd_chk(12'h00C, 32'h3FF, "R9 no re-ack");
        rd_chk(12'h204, 32'h0000_0002, "R8 active set");
        wr(12'h010, 32'd33);
        irq_chk(1'b1, "R9 level after eoi");
        rd_chk(12'h00C, 32'd33, "R9 re-ack after eoi");
        irq_in[33] = 1'b0;
        wr(12'h010, 32'd33);
        rd_chk(12'h204, 32'h0, "R9 eoi clears");

        // R5 ordering and ties
        irq_in[5] = 1'b1; irq_in[33] = 1'b1; irq_in[40] = 1'b1;
        rd_chk(12'h00C, 32'd5, "R5 tie lowest id");
        rd_chk(12'h00C, 32'd40, "R5 second");
        rd_chk(12'h00C, 32'd33, "R5 third");
        rd_chk(12'h00C, 32'h3FF, "R8 exhausted");
        irq_chk(1'b0, "R9 all active");
        irq_in = '0;
        wr(12'h010, 32'd5);
        wr(12'h010, 32'd40);
        wr(12'h010, 32'd33);

        // R9 ignored EOIs and R10 active reset
        wr(12'h204, 32'h0000_0100);
        wr(12'h010, 32'd1023);
        wr(12'h010, 32'd5);
        rd_chk(12'h204, 32'h0000_0100, "R9 stray eoi ignored");
        irq_in[40] = 1'b1;
        irq_chk(1'b0, "R9 software active blocks");
        rd_chk(12'h184, 32'h0000_0100, "R3 pending while active");
        wr(12'h014, 32'h5);
        rd_chk(12'h204, 32'h0000_0100, "R10 nonzero ignored");
        wr(12'h014, 32'h0);
        rd_chk(12'h244, 32'h0, "R10 all cleared");
        irq_chk(1'b1, "R10 line returns");
        irq_in[40] = 1'b0;
        irq_chk(1'b0, "R11 line drop");

        // R6 mask
        irq_in[5] = 1'b1; irq_in[40] = 1'b1;
        wr(12'h008, 32'h40);
        irq_chk(1'b0, "R6 equal masked");
        rd_chk(12'h00C, 32'h3FF, "R6 ack masked");
        wr(12'h008, 32'h41);
        irq_chk(1'b1, "R6 below passes");
        rd_chk(12'h00C, 32'd5, "R6 ack passes");
        wr(12'h008, 32'hFF);
        irq_in = '0;
        wr(12'h010, 32'd5);

        // R7 enables
        irq_in[40] = 1'b1;
        wr(12'h000, 32'h0);
        irq_chk(1'b0, "R7 forward off");
        rd_chk(12'h00C, 32'h3FF, "R7 ack forward off");
        wr(12'h000, 32'h1);
        wr(12'h004, 32'h0);
        irq_chk(1'b0, "R7 cpu off");
        wr(12'h004, 32'h1);
        irq_chk(1'b1, "R7 both on");
        rd_chk(12'h000, 32'h1, "R7 ctrl readback");

        // R2 clear-enable
        wr(12'h144, 32'h0000_0100);
        irq_chk(1'b0, "R2 cleared line quiet");
        rd_chk(12'h104, 32'h0000_0002, "R2 clear-enable");
        rd_chk(12'h144, 32'h0000_0002, "R2 clear bank read");
        irq_in[40] = 1'b0;

        // R3 software pending
        wr(12'h180, 32'h0000_0020);
        irq_chk(1'b1, "R3 soft pending");
        rd_chk(12'h180, 32'h0000_0020, "R3 soft read");
        wr(12'h1C0, 32'h0000_0020);
        irq_chk(1'b0, "R3 soft cleared");
        rd_chk(12'h180, 32'h0, "R3 cleared read");
        wr(12'h180, 32'h0000_0020);
        rd_chk(12'h00C, 32'd5, "R8 ack soft");
        rd_chk(12'h180, 32'h0, "R8 soft consumed");
        wr(12'h010, 32'd5);
        irq_chk(1'b0, "R11 final quiet");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            miscompares++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        summary();
    end
endmodule